// File: doc/BRIEF.md
# Interrupt Redirection Message Engine

This block turns a bank of interrupt request lines into message-signalled interrupts. Each line has its own routing entry, given as configuration inputs: vector, delivery mode, destination, destination mode, trigger mode, polarity and mask. When a line needs service, the block builds an address/data pair from the routing entry and a shared base address. It presents the pair on a valid/ready write channel, one message at a time, and chooses among competing lines in round-robin order.

Lines in level mode carry an in-service flag. Accepting a message sets the flag, and while the flag is set the line makes no further request. An end-of-interrupt broadcast carrying a vector clears the flag on every level-mode entry that uses that vector. Lines in edge mode latch one pending request per active edge. Further edges that arrive before the message is accepted fold into the request already pending.

Top module: `msi_route_engine`

## Requirements
- R1: After synchronous reset, `msg_valid`, `dlv_status` and `remote_irr` are all zero.
- R2: The message low address is `msg_base` OR (8-bit destination << 12) OR (1 << 3) OR (destination-mode bit << 2). The destination is always the full 8 bits, whatever the destination mode. `msg_addr_hi` is always zero.
- R3: The message data is (trigger-mode bit << 15) OR (in-service flag << 14) OR (3-bit delivery mode << 8) OR the 8-bit vector. All eight delivery-mode codes are copied unchanged.
- R4: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr_lo` and `msg_data` hold their values.
- R5: An edge-mode line (trigger bit 0) requests on the edge where it becomes active. The line is active when `irq_in` XOR its polarity bit is 1, so polarity 1 means active-low.
- R6: An entry with its mask bit set produces no message. An edge that arrives while the entry is masked is discarded and does not come back when the entry is unmasked.
- R7: A level-mode line (trigger bit 1) requests while it is active and its in-service flag is clear. Acceptance of its message sets `remote_irr` for that line, and no further message comes from it until the flag is cleared.
- R8: An end-of-interrupt with vector V clears `remote_irr` only on entries that are in level mode with vector V. Entries in edge mode keep the flag as it is.
- R9: If an end-of-interrupt and the acceptance of a message for the same level entry happen in the same cycle, `remote_irr` ends up set.
- R10: Pending requests are granted round-robin. The search starts at the line after the one granted last and wraps around, with line 0 first after reset.
- R11: Edges on a line whose earlier request has not yet been accepted merge into that request and yield a single message.
- R12: `dlv_status` of a line is high while an unmasked request from it is outstanding and not yet accepted, and low once it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IN | Interrupt request lines |
| cfg_polarity | input | N_IN | Per-line polarity, 1 = active low |
| cfg_level | input | N_IN | Per-line trigger mode, 1 = level |
| cfg_mask | input | N_IN | Per-line mask, 1 = masked |
| cfg_dest_mode | input | N_IN | Per-line destination-mode bit |
| cfg_dlv_mode | input | 3*N_IN | Per-line delivery mode, line i at bits 3i+2:3i |
| cfg_vector | input | 8*N_IN | Per-line vector, line i at bits 8i+7:8i |
| cfg_dest | input | 8*N_IN | Per-line destination, line i at bits 8i+7:8i |
| msg_base | input | 32 | Base address ORed into every message address |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the broadcast |
| msg_valid | output | 1 | Message pending on the channel |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr_lo | output | 32 | Message address, low word |
| msg_addr_hi | output | 32 | Message address, high word (zero) |
| msg_data | output | 32 | Message data |
| dlv_status | output | N_IN | Per-line delivery-status bits |
| remote_irr | output | N_IN | Per-line in-service flags |

## Verification
The hardest case to reach is an end-of-interrupt that lands in exactly the cycle a level-mode message is accepted. The bench stalls `msg_ready` until the message sits on the channel, then raises ready and the matching end-of-interrupt at the same falling edge. A similar problem is showing that an edge-mode flag survives an end-of-interrupt. The only way to give an edge-mode entry a set flag is to service it in level mode first and then switch its trigger bit, and the bench does exactly that. The round-robin order is checked after earlier grants have moved the pointer, so that the wrap-around is exercised.

// File: rtl/msi_route_pkg.sv
package msi_route_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int VEC_W     = 8;
    localparam int DEST_W    = 8;
    localparam int DMODE_W   = 3;

    localparam int HINT_POS  = 3;
    localparam int DMODE_POS = 2;
    localparam int DEST_POS  = 12;
    localparam int TRIG_POS  = 15;
    localparam int IRR_POS   = 14;
    localparam int DLV_POS   = 8;

    typedef struct packed {
        logic [VEC_W-1:0]   vector;
        logic [DMODE_W-1:0] dlv_mode;
        logic               dest_mode;
        logic               level;
        logic [DEST_W-1:0]  dest;
    } route_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } msi_msg_t;

    function automatic logic [ADDR_W-1:0] build_addr(
        input logic [ADDR_W-1:0] base,
        input route_cfg_t        cfg
    );
        logic [ADDR_W-1:0] a;
        a = base;
        a = a | (ADDR_W'(cfg.dest) << DEST_POS);
        a = a | (ADDR_W'(1) << HINT_POS);
        a = a | (ADDR_W'(cfg.dest_mode) << DMODE_POS);
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] build_data(
        input route_cfg_t cfg,
        input logic       irr
    );
        logic [DATA_W-1:0] d;
        d = DATA_W'(cfg.vector);
        d = d | (DATA_W'(cfg.dlv_mode) << DLV_POS);
        d = d | (DATA_W'(irr) << IRR_POS);
        d = d | (DATA_W'(cfg.level) << TRIG_POS);
        return d;
    endfunction

endpackage

// File: rtl/msi_src_tracker.sv
module msi_src_tracker
    import msi_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             irq,
    input  logic             polarity,
    input  logic             level,
    input  logic             mask,
    input  logic [VEC_W-1:0] vector,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             accept,
    output logic             req,
    output logic             dlv_status,
    output logic             rirr
);

    logic active;
    logic active_q;
    logic edge_seen;
    logic edge_pend;
    logic level_req;
    logic eoi_hit;

    assign active    = irq ^ polarity;
    assign edge_seen = active & ~active_q;
    assign level_req = level & active & ~rirr;
    assign eoi_hit   = eoi_valid & level & (vector == eoi_vector);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b1;
            edge_pend <= 1'b0;
            rirr      <= 1'b0;
        end else begin
            active_q <= active;
            if (level) begin
                edge_pend <= 1'b0;
            end else begin
                edge_pend <= (edge_pend & ~accept) | (edge_seen & ~mask);
            end
            if (accept && level) begin
                rirr <= 1'b1;
            end else if (eoi_hit) begin
                rirr <= 1'b0;
            end
        end
    end

    assign req        = ~mask & (level ? level_req : edge_pend);
    assign dlv_status = req;

endmodule

// File: rtl/msi_rr_arbiter.sv
module msi_rr_arbiter #(
    parameter int N_REQ = 24,
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req,
    input  logic             enable,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);

    logic [IDX_W-1:0] last_q;
    logic             found;
    int               cand;

    always_comb begin
        found   = 1'b0;
        gnt_idx = '0;
        cand    = 0;
        for (int off = N_REQ; off >= 1; off--) begin
            cand = (int'(last_q) + off) % N_REQ;
            if (req[cand]) begin
                found   = 1'b1;
                gnt_idx = IDX_W'(cand);
            end
        end
    end

    assign gnt_valid = found & enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IDX_W'(N_REQ - 1);
        end else if (gnt_valid) begin
            last_q <= gnt_idx;
        end
    end

endmodule

// File: rtl/msi_msg_port.sv
module msi_msg_port
    import msi_route_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  msi_msg_t         load_msg,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             ready,
    output logic             valid,
    output msi_msg_t         msg,
    output logic [IDX_W-1:0] idx,
    output logic             accept
);

    assign accept = valid & ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            msg   <= '0;
            idx   <= '0;
        end else if (accept) begin
            valid <= 1'b0;
        end else if (load && !valid) begin
            valid <= 1'b1;
            msg   <= load_msg;
            idx   <= load_idx;
        end
    end

endmodule

// File: rtl/msi_route_engine.sv
module msi_route_engine
    import msi_route_pkg::*;
#(
    parameter int N_IN = 24,
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_IN-1:0]         irq_in,
    input  logic [N_IN-1:0]         cfg_polarity,
    input  logic [N_IN-1:0]         cfg_level,
    input  logic [N_IN-1:0]         cfg_mask,
    input  logic [N_IN-1:0]         cfg_dest_mode,
    input  logic [N_IN*DMODE_W-1:0] cfg_dlv_mode,
    input  logic [N_IN*VEC_W-1:0]   cfg_vector,
    input  logic [N_IN*DEST_W-1:0]  cfg_dest,
    input  logic [ADDR_W-1:0]       msg_base,
    input  logic                    eoi_valid,
    input  logic [VEC_W-1:0]        eoi_vector,
    output logic                    msg_valid,
    input  logic                    msg_ready,
    output logic [ADDR_W-1:0]       msg_addr_lo,
    output logic [ADDR_W-1:0]       msg_addr_hi,
    output logic [DATA_W-1:0]       msg_data,
    output logic [N_IN-1:0]         dlv_status,
    output logic [N_IN-1:0]         remote_irr
);

    route_cfg_t       cfg_arr [N_IN];
    logic [N_IN-1:0]  src_req;
    logic [N_IN-1:0]  acc_vec;
    logic             gnt_valid;
    logic [IDX_W-1:0] gnt_idx;
    logic             accept;
    logic [IDX_W-1:0] acc_idx;
    route_cfg_t       sel_cfg;
    logic             sel_irr;
    msi_msg_t         next_msg;
    msi_msg_t         cur_msg;

    for (genvar g = 0; g < N_IN; g++) begin : g_src
        assign cfg_arr[g].vector    = cfg_vector[g*VEC_W +: VEC_W];
        assign cfg_arr[g].dlv_mode  = cfg_dlv_mode[g*DMODE_W +: DMODE_W];
        assign cfg_arr[g].dest_mode = cfg_dest_mode[g];
        assign cfg_arr[g].level     = cfg_level[g];
        assign cfg_arr[g].dest      = cfg_dest[g*DEST_W +: DEST_W];

        msi_src_tracker u_trk (
            .clk        (clk),
            .rst        (rst),
            .irq        (irq_in[g]),
            .polarity   (cfg_polarity[g]),
            .level      (cfg_level[g]),
            .mask       (cfg_mask[g]),
            .vector     (cfg_vector[g*VEC_W +: VEC_W]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .accept     (acc_vec[g]),
            .req        (src_req[g]),
            .dlv_status (dlv_status[g]),
            .rirr       (remote_irr[g])
        );
    end

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            acc_vec[i] = accept && (acc_idx == IDX_W'(i));
        end
    end

    msi_rr_arbiter #(.N_REQ(N_IN)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (src_req),
        .enable    (!msg_valid),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    always_comb begin
        sel_cfg = cfg_arr[0];
        sel_irr = remote_irr[0];
        for (int i = 1; i < N_IN; i++) begin
            if (gnt_idx == IDX_W'(i)) begin
                sel_cfg = cfg_arr[i];
                sel_irr = remote_irr[i];
            end
        end
        next_msg.addr = build_addr(msg_base, sel_cfg);
        next_msg.data = build_data(sel_cfg, sel_irr);
    end

    msi_msg_port #(.IDX_W(IDX_W)) u_port (
        .clk      (clk),
        .rst      (rst),
        .load     (gnt_valid),
        .load_msg (next_msg),
        .load_idx (gnt_idx),
        .ready    (msg_ready),
        .valid    (msg_valid),
        .msg      (cur_msg),
        .idx      (acc_idx),
        .accept   (accept)
    );

    assign msg_addr_lo = cur_msg.addr;
    assign msg_data    = cur_msg.data;
    assign msg_addr_hi = '0;

endmodule

// File: rtl/msi_route_engine_chk.sv
module msi_route_engine_chk #(
    parameter int N_IN = 24,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [31:0]      msg_addr_lo,
    input logic [31:0]      msg_data,
    input logic             gnt_valid,
    input logic [IDX_W-1:0] gnt_idx,
    input logic [N_IN-1:0]  cfg_mask,
    input logic [N_IN-1:0]  cfg_level,
    input logic             accept,
    input logic [IDX_W-1:0] acc_idx,
    input logic [N_IN-1:0]  remote_irr
);

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr_lo) && $stable(msg_data));

    a_r6_no_masked_grant: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> !cfg_mask[gnt_idx]);

    a_r10_one_at_a_time: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !gnt_valid);

    a_r7_irr_set: assert property (@(posedge clk) disable iff (rst)
        accept && cfg_level[acc_idx] |=> remote_irr[$past(acc_idx)]);

    a_r7_no_grant_in_service: assert property (@(posedge clk) disable iff (rst)
        gnt_valid && cfg_level[gnt_idx] |-> !remote_irr[gnt_idx]);

endmodule

bind msi_route_engine msi_route_engine_chk #(.N_IN(N_IN), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_addr_lo (msg_addr_lo),
    .msg_data    (msg_data),
    .gnt_valid   (gnt_valid),
    .gnt_idx     (gnt_idx),
    .cfg_mask    (cfg_mask),
    .cfg_level   (cfg_level),
    .accept      (accept),
    .acc_idx     (acc_idx),
    .remote_irr  (remote_irr)
);

// File: tb/msi_route_engine_test.sv
module msi_route_engine_test;

    localparam int N = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [N-1:0]   irq = '0, pol = '0, lvl = '0, msk = '1, dmo = '0;
    logic [7:0]     vec [N];
    logic [7:0]     dst [N];
    logic [2:0]     dm  [N];
    logic [N*3-1:0] f_dm;
    logic [N*8-1:0] f_vec, f_dst;
    logic [31:0]    base = 32'hFEE0_0000;
    logic           eoi_v = 1'b0;
    logic [7:0]     eoi_vec = '0;
    logic           ready = 1'b0;
    logic           msg_valid;
    logic [31:0]    addr_lo, addr_hi, data;
    logic [N-1:0]   dlv, rirr;

    int n_tests = 0;
    int n_fail  = 0;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            f_dm[i*3 +: 3]  = dm[i];
            f_vec[i*8 +: 8] = vec[i];
            f_dst[i*8 +: 8] = dst[i];
        end
    end

    msi_route_engine #(.N_IN(N)) uut (
        .clk(clk), .rst(rst), .irq_in(irq), .cfg_polarity(pol), .cfg_level(lvl),
        .cfg_mask(msk), .cfg_dest_mode(dmo), .cfg_dlv_mode(f_dm), .cfg_vector(f_vec),
        .cfg_dest(f_dst), .msg_base(base), .eoi_valid(eoi_v), .eoi_vector(eoi_vec),
        .msg_valid(msg_valid), .msg_ready(ready), .msg_addr_lo(addr_lo),
        .msg_addr_hi(addr_hi), .msg_data(data), .dlv_status(dlv), .remote_irr(rirr)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_actq [N];
    bit          m_pend [N];
    bit          m_rirr [N];
    int          m_last;
    bit          m_busy;
    int          m_idx;
    logic [31:0] m_addr, m_data;

    function automatic bit m_req(int i);
        bit act;
        act = irq[i] ^ pol[i];
        if (msk[i]) return 1'b0;
        if (lvl[i]) return act && !m_rirr[i];
        return m_pend[i];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_actq[i] = 1'b1; m_pend[i] = 1'b0; m_rirr[i] = 1'b0;
            end
            m_last = N - 1; m_busy = 1'b0; m_idx = 0; m_addr = '0; m_data = '0;
        end else begin
            bit acc;
            int g;
            int c;
            acc = m_busy && ready;
            g = -1;
            if (!m_busy) begin
                for (int off = 1; off <= N; off++) begin
                    c = (m_last + off) % N;
                    if (g < 0 && m_req(c)) g = c;
                end
            end
            for (int i = 0; i < N; i++) begin
                bit act;
                bit acc_i;
                act   = irq[i] ^ pol[i];
                acc_i = acc && (m_idx == i);
                if (lvl[i]) m_pend[i] = 1'b0;
                else m_pend[i] = (m_pend[i] && !acc_i) || (act && !m_actq[i] && !msk[i]);
                if (acc_i && lvl[i]) m_rirr[i] = 1'b1;
                else if (eoi_v && lvl[i] && vec[i] == eoi_vec) m_rirr[i] = 1'b0;
                m_actq[i] = act;
            end
            if (acc) begin
                m_busy = 1'b0;
            end else if (g >= 0) begin
                m_busy = 1'b1;
                m_idx  = g;
                m_last = g;
                m_addr = base | (32'(dst[g]) << 12) | 32'h8 | (32'(dmo[g]) << 2);
                m_data = (32'(lvl[g]) << 15) | (32'(m_rirr[g]) << 14)
                       | (32'(dm[g]) << 8) | 32'(vec[g]);
            end
        end
    end

    // per-cycle comparison (runs before the fresh-block events of the initial block)
    always @(negedge clk) begin
        if (!rst) begin
            logic [N-1:0] e_rirr, e_dlv;
            for (int i = 0; i < N; i++) begin
                e_rirr[i] = m_rirr[i];
                e_dlv[i]  = m_req(i);
            end
            n_tests++;
            if (msg_valid !== m_busy || (m_busy && (addr_lo !== m_addr || data !== m_data))
                || addr_hi !== 32'h0) begin
                n_fail++;
                $display("FAIL R2/R3/R4 model msg: act v=%0b a=%h d=%h exp v=%0b a=%h d=%h",
                         msg_valid, addr_lo, data, m_busy, m_addr, m_data);
            end
            n_tests++;
            if (rirr !== e_rirr || dlv !== e_dlv) begin
                n_fail++;
                $display("FAIL R7/R12 model flags: act irr=%h dlv=%h exp irr=%h dlv=%h",
                         rirr, dlv, e_rirr, e_dlv);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pulse(input int i);
        irq[i] = ~pol[i];
        @(negedge clk);
        irq[i] = pol[i];
    endtask

    task automatic wait_msg(output bit got);
        got = 1'b0;
        for (int k = 0; k < 20 && !got; k++) begin
            @(negedge clk);
            if (msg_valid) got = 1'b1;
        end
    endtask

    task automatic take();
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
    endtask

    task automatic no_msg(input int n, input string tag);
        bit seen;
        seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(!seen, tag, 32'(seen), 32'h0);
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_v = 1'b1; eoi_vec = v;
        @(negedge clk);
        eoi_v = 1'b0;
    endtask

    task automatic set_entry(input int i, input logic [7:0] v, input logic [2:0] m,
                             input logic [7:0] d, input logic dmode, input logic level);
        vec[i] = v; dm[i] = m; dst[i] = d; dmo[i] = dmode; lvl[i] = level;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit got;
        logic [31:0] hold_a, hold_d;
        logic [7:0]  order [3];
        for (int i = 0; i < N; i++) begin
            vec[i] = 8'(i); dst[i] = '0; dm[i] = '0;
        end
        pol[5] = 1'b1; irq[5] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!msg_valid && rirr == '0 && dlv == '0, "R1 reset state", {msg_valid, 7'(0), rirr}, 32'h0);

        // R2 R3 R4 R12: edge line 3, SMI mode, logical destination
        set_entry(3, 8'h41, 3'd2, 8'hA5, 1'b1, 1'b0); msk[3] = 1'b0;
        pulse(3);
        check(dlv[3] === 1'b1, "R12 status while pending", 32'(dlv[3]), 32'h1);
        wait_msg(got);
        check(got && addr_lo == 32'hFEEA_500C, "R2 address", addr_lo, 32'hFEEA_500C);
        check(data == 32'h0000_0241, "R3 data", data, 32'h0000_0241);
        check(addr_hi == 32'h0, "R2 high address", addr_hi, 32'h0);
        hold_a = addr_lo; hold_d = data;
        repeat (3) @(negedge clk);
        check(msg_valid && addr_lo == hold_a && data == hold_d, "R4 hold", data, hold_d);
        take();
        check(dlv[3] === 1'b0 && !msg_valid, "R12 status after accept", 32'(dlv[3]), 32'h0);

        // R5: active-low edge line 5
        set_entry(5, 8'h45, 3'd0, 8'h01, 1'b0, 1'b0); msk[5] = 1'b0;
        no_msg(3, "R5 no request while idle-high");
        pulse(5);
        wait_msg(got);
        check(got && addr_lo == 32'hFEE0_1008 && data == 32'h45, "R5 falling edge message", data, 32'h45);
        take();
        no_msg(5, "R5 rising edge ignored");

        // R6: masked edge discarded
        set_entry(7, 8'h47, 3'd0, 8'h00, 1'b0, 1'b0);
        pulse(7);
        no_msg(5, "R6 masked edge");
        msk[7] = 1'b0;
        no_msg(5, "R6 no message after unmask");

        // R7: level line 10, lowest-priority mode
        set_entry(10, 8'h55, 3'd1, 8'h10, 1'b0, 1'b1); msk[10] = 1'b0;
        irq[10] = 1'b1;
        wait_msg(got);
        check(got && addr_lo == 32'hFEE1_0008 && data == 32'h0000_8155, "R7 level message", data, 32'h8155);
        take();
        check(rirr[10] === 1'b1, "R7 flag set on accept", 32'(rirr[10]), 32'h1);
        no_msg(5, "R7 no repeat while in service");
        eoi(8'h56);
        check(rirr[10] === 1'b1, "R8 other vector keeps flag", 32'(rirr[10]), 32'h1);
        eoi(8'h55);
        check(rirr[10] === 1'b0, "R8 matching vector clears flag", 32'(rirr[10]), 32'h0);
        wait_msg(got);
        check(got && data == 32'h0000_8155, "R7 redelivery after clear", data, 32'h8155);

        // R9: EOI in the acceptance cycle
        ready = 1'b1; eoi_v = 1'b1; eoi_vec = 8'h55;
        @(negedge clk);
        ready = 1'b0; eoi_v = 1'b0;
        check(rirr[10] === 1'b1, "R9 set wins over clear", 32'(rirr[10]), 32'h1);
        irq[10] = 1'b0;
        eoi(8'h55);

        // R8: edge-mode entry keeps its flag
        set_entry(12, 8'h66, 3'd0, 8'h00, 1'b0, 1'b1); msk[12] = 1'b0;
        irq[12] = 1'b1;
        wait_msg(got);
        take();
        irq[12] = 1'b0;
        @(negedge clk);
        lvl[12] = 1'b0;
        eoi(8'h66);
        check(rirr[12] === 1'b1, "R8 edge entry untouched", 32'(rirr[12]), 32'h1);

        // R10: round robin after last grant on line 12
        set_entry(1, 8'h31, 3'd0, 8'h00, 1'b0, 1'b0); msk[1] = 1'b0;
        set_entry(2, 8'h32, 3'd0, 8'h00, 1'b0, 1'b0); msk[2] = 1'b0;
        set_entry(20, 8'h50, 3'd0, 8'h00, 1'b0, 1'b0); msk[20] = 1'b0;
        irq[1] = 1'b1; irq[2] = 1'b1; irq[20] = 1'b1;
        @(negedge clk);
        irq[1] = 1'b0; irq[2] = 1'b0; irq[20] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            wait_msg(got);
            order[k] = data[7:0];
            take();
        end
        check(order[0] == 8'h50, "R10 first grant wraps from 12", 32'(order[0]), 32'h50);
        check(order[1] == 8'h31, "R10 second grant", 32'(order[1]), 32'h31);
        check(order[2] == 8'h32, "R10 third grant", 32'(order[2]), 32'h32);

        // R11: repeated edges merge
        set_entry(4, 8'h34, 3'd0, 8'h00, 1'b0, 1'b0); msk[4] = 1'b0;
        pulse(4);
        @(negedge clk);
        pulse(4);
        wait_msg(got);
        pulse(4);
        check(got && data == 32'h34, "R11 merged message", data, 32'h34);
        take();
        no_msg(6, "R11 single message");

        // R3: every delivery mode passes through
        set_entry(6, 8'h60, 3'd0, 8'h00, 1'b0, 1'b0); msk[6] = 1'b0;
        for (int m = 0; m < 8; m++) begin
            dm[6] = 3'(m);
            pulse(6);
            wait_msg(got);
            check(got && data == ((32'(m) << 8) | 32'h60), "R3 delivery mode", data,
                  (32'(m) << 8) | 32'h60);
            take();
        end

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule